// File: doc/BRIEF.md
# SATA Out-of-Band Signal Generator and Detector

This block makes and recognises the out-of-band (OOB) signals that a SATA physical layer uses at power-on. These are COMRESET/COMINIT and COMWAKE. The block needs no serial data pattern to do this. On the transmit side it switches the transceiver's electrical-idle control. Over each signal it produces a series of burst periods separated by idle gaps. During a burst it also supplies the ALIGN primitive as 16-bit parallel words. On the receive side it times the gaps seen on the transceiver's signal-detect line. It then reports which kind of OOB signal arrived.

A physical-layer state machine drives the block. It requests a signal with `tx_start` and `tx_kind`, and waits for `tx_done`. It listens for one-cycle pulses on `rx_cominit` or `rx_comwake`. All durations are counted in parallel-clock cycles and set by parameters:

| Parameter | Default |
|---|---|
| `BURST_CYC` | 16 |
| `RESET_GAP_CYC` | 48 |
| `WAKE_GAP_CYC` | 16 |
| `NUM_BURSTS` | 6 |
| `INIT_GAP_MIN` / `INIT_GAP_MAX` | 26 / 79 |
| `WAKE_GAP_MIN` / `WAKE_GAP_MAX` | 8 / 25 |
| `MATCH_GAPS` | 4 |

Top module: `oob_signal_unit`

## Requirements
- R1: While reset is high and just after it is released:
  - `tx_elec_idle` is 1.
  - `tx_busy`, `tx_done`, `rx_cominit` and `rx_comwake` are 0.
  - `tx_data` and `tx_isk` are 0.
- R2: A `tx_start` that is sampled high while the block is not busy begins a signal from the next cycle. The signal has `NUM_BURSTS` bursts, and in each burst `tx_elec_idle` is 0 for exactly `BURST_CYC` cycles.
- R3: Between consecutive bursts `tx_elec_idle` is 1. The gap lasts `RESET_GAP_CYC` cycles when `tx_kind` was 0 at the start (COMRESET/COMINIT). It lasts `WAKE_GAP_CYC` cycles when `tx_kind` was 1 (COMWAKE).
- R4: During a burst, `tx_data`/`tx_isk` follow the burst-cycle offset counted from 0:
  - at even offsets they are 16'h4ABC with `tx_isk` = 2'b01, a K flag on the low byte;
  - at odd offsets they are 16'h7B4A with `tx_isk` = 2'b00;
  - whenever `tx_elec_idle` is 1, both are 0.
- R5: `tx_busy` is 1 from the first burst cycle through the last burst cycle. In the cycle right after the last burst cycle, `tx_done` is 1 for one cycle while `tx_busy` is 0.
- R6: A `tx_start` sampled while `tx_busy` is 1 is ignored: the running signal's waveform and kind are unchanged.
- R7: On each 0-to-1 change of `rx_sig_det`, the idle gap just ended is classed by its length in cycles:
  - COMINIT class if the length lies in [`INIT_GAP_MIN`, `INIT_GAP_MAX`];
  - COMWAKE class if it lies in [`WAKE_GAP_MIN`, `WAKE_GAP_MAX`];
  - otherwise no class.
  A gap counts only if some burst was seen on `rx_sig_det` after reset and before it.
- R8: When `MATCH_GAPS` consecutive gaps have the same class, a one-cycle pulse appears on `rx_cominit` or `rx_comwake`. It comes in the cycle after the rising edge that ends the last of those gaps. The run count then restarts from zero.
- R9: A gap with no class clears the run count. A gap of the other class restarts the count at one for the new class.
- R10: When `rx_sig_det` is the inverse of `tx_elec_idle`, each transmitted signal produces exactly one report of its own kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-word clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Request to send one OOB signal |
| tx_kind | input | 1 | 0 = COMRESET/COMINIT, 1 = COMWAKE; sampled with `tx_start` |
| tx_elec_idle | output | 1 | Transceiver force-idle control, 1 = idle (high impedance) |
| tx_data | output | 16 | Parallel transmit word |
| tx_isk | output | 2 | Per-byte K-character flags for `tx_data` |
| tx_busy | output | 1 | A signal is being sent |
| tx_done | output | 1 | One-cycle pulse when a signal has finished |
| rx_sig_det | input | 1 | Receive signal-detect, 1 = burst present |
| rx_cominit | output | 1 | One-cycle pulse: COMRESET/COMINIT recognised |
| rx_comwake | output | 1 | One-cycle pulse: COMWAKE recognised |

## Verification
The properties assume that `rx_sig_det` is already synchronous to `clk`, so each sample is a clean level. They also assume that `tx_start` is a level that is meaningful only on clock edges. The bench drives every input on the falling clock edge and changes `rx_sig_det` only in whole-cycle steps. In the loopback test it derives the signal-detect level straight from the registered idle control. Random gap lengths are drawn across and just outside each class window, so the classifier's boundaries are reached without any input breaking those assumptions.

// File: rtl/oob_pkg.sv
package oob_pkg;

  typedef enum logic [1:0] {
    GAP_NONE = 2'd0,
    GAP_INIT = 2'd1,
    GAP_WAKE = 2'd2
  } gap_class_e;

  typedef enum logic [1:0] {
    TX_QUIET = 2'd0,
    TX_BURST = 2'd1,
    TX_GAP   = 2'd2
  } tx_phase_e;

  // ALIGN primitive split into two 16-bit halves, low half first
  localparam logic [15:0] ALIGN_LO     = 16'h4ABC;
  localparam logic [15:0] ALIGN_HI     = 16'h7B4A;
  localparam logic [1:0]  ALIGN_LO_ISK = 2'b01;
  localparam logic [1:0]  ALIGN_HI_ISK = 2'b00;

endpackage

// File: rtl/oob_tx_gen.sv
module oob_tx_gen
  import oob_pkg::*;
#(
  parameter int BURST_CYC     = 16,
  parameter int RESET_GAP_CYC = 48,
  parameter int WAKE_GAP_CYC  = 16,
  parameter int NUM_BURSTS    = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        kind,
  output logic        elec_idle,
  output logic [15:0] data,
  output logic [1:0]  isk,
  output logic        busy,
  output logic        done
);

  localparam int SPAN_A = (BURST_CYC > RESET_GAP_CYC) ? BURST_CYC : RESET_GAP_CYC;
  localparam int SPAN   = (SPAN_A > WAKE_GAP_CYC) ? SPAN_A : WAKE_GAP_CYC;
  localparam int CNT_W  = $clog2(SPAN + 1);
  localparam int IDX_W  = $clog2(NUM_BURSTS + 1);

  localparam logic [CNT_W-1:0] BURST_LAST = CNT_W'(BURST_CYC - 1);
  localparam logic [CNT_W-1:0] RGAP_LAST  = CNT_W'(RESET_GAP_CYC - 1);
  localparam logic [CNT_W-1:0] WGAP_LAST  = CNT_W'(WAKE_GAP_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(NUM_BURSTS - 1);

  tx_phase_e        phase_q, phase_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             kind_q, kind_n;
  logic             done_n;
  logic [CNT_W-1:0] gap_last;

  assign gap_last = kind_q ? WGAP_LAST : RGAP_LAST;

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    kind_n  = kind_q;
    done_n  = 1'b0;
    unique case (phase_q)
      TX_QUIET: begin
        if (start) begin
          phase_n = TX_BURST;
          cnt_n   = '0;
          idx_n   = '0;
          kind_n  = kind;
        end
      end
      TX_BURST: begin
        if (cnt_q == BURST_LAST) begin
          cnt_n = '0;
          if (idx_q == IDX_LAST) begin
            phase_n = TX_QUIET;
            done_n  = 1'b1;
          end else begin
            phase_n = TX_GAP;
          end
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      TX_GAP: begin
        if (cnt_q == gap_last) begin
          phase_n = TX_BURST;
          cnt_n   = '0;
          idx_n   = idx_q + IDX_W'(1);
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      default: phase_n = TX_QUIET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= TX_QUIET;
      cnt_q     <= '0;
      idx_q     <= '0;
      kind_q    <= 1'b0;
      elec_idle <= 1'b1;
      data      <= '0;
      isk       <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      phase_q   <= phase_n;
      cnt_q     <= cnt_n;
      idx_q     <= idx_n;
      kind_q    <= kind_n;
      elec_idle <= (phase_n != TX_BURST);
      busy      <= (phase_n != TX_QUIET);
      done      <= done_n;
      if (phase_n == TX_BURST) begin
        data <= cnt_n[0] ? ALIGN_HI : ALIGN_LO;
        isk  <= cnt_n[0] ? ALIGN_HI_ISK : ALIGN_LO_ISK;
      end else begin
        data <= '0;
        isk  <= '0;
      end
    end
  end

endmodule

// File: rtl/oob_gap_class.sv
module oob_gap_class
  import oob_pkg::*;
#(
  parameter int LEN_W        = 7,
  parameter int INIT_GAP_MIN = 26,
  parameter int INIT_GAP_MAX = 79,
  parameter int WAKE_GAP_MIN = 8,
  parameter int WAKE_GAP_MAX = 25
) (
  input  logic [LEN_W-1:0] len,
  output gap_class_e       cls
);

  localparam logic [LEN_W-1:0] I_LO = LEN_W'(INIT_GAP_MIN);
  localparam logic [LEN_W-1:0] I_HI = LEN_W'(INIT_GAP_MAX);
  localparam logic [LEN_W-1:0] W_LO = LEN_W'(WAKE_GAP_MIN);
  localparam logic [LEN_W-1:0] W_HI = LEN_W'(WAKE_GAP_MAX);

  always_comb begin
    if (len >= I_LO && len <= I_HI)      cls = GAP_INIT;
    else if (len >= W_LO && len <= W_HI) cls = GAP_WAKE;
    else                                 cls = GAP_NONE;
  end

endmodule

// File: rtl/oob_rx_detect.sv
module oob_rx_detect
  import oob_pkg::*;
#(
  parameter int INIT_GAP_MIN = 26,
  parameter int INIT_GAP_MAX = 79,
  parameter int WAKE_GAP_MIN = 8,
  parameter int WAKE_GAP_MAX = 25,
  parameter int MATCH_GAPS   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_det,
  output logic seen_init,
  output logic seen_wake
);

  localparam int LEN_W    = $clog2(INIT_GAP_MAX + 2);
  localparam int STREAK_W = $clog2(MATCH_GAPS + 1);
  localparam logic [LEN_W-1:0]    LEN_SAT  = LEN_W'(INIT_GAP_MAX + 1);
  localparam logic [STREAK_W-1:0] MATCH_AT = STREAK_W'(MATCH_GAPS);

  logic                det_prev;
  logic                had_burst;
  logic [LEN_W-1:0]    gap_len;
  logic [STREAK_W-1:0] streak_q, streak_n;
  gap_class_e          cls_now, cls_q;
  logic                rise;

  oob_gap_class #(
    .LEN_W       (LEN_W),
    .INIT_GAP_MIN(INIT_GAP_MIN),
    .INIT_GAP_MAX(INIT_GAP_MAX),
    .WAKE_GAP_MIN(WAKE_GAP_MIN),
    .WAKE_GAP_MAX(WAKE_GAP_MAX)
  ) class_i (
    .len(gap_len),
    .cls(cls_now)
  );

  assign rise = sig_det && !det_prev;

  // run length if the gap just closed is accepted
  always_comb begin
    if (cls_now == cls_q) streak_n = streak_q + STREAK_W'(1);
    else                  streak_n = STREAK_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_prev  <= 1'b0;
      had_burst <= 1'b0;
      gap_len   <= '0;
      streak_q  <= '0;
      cls_q     <= GAP_NONE;
      seen_init <= 1'b0;
      seen_wake <= 1'b0;
    end else begin
      det_prev  <= sig_det;
      seen_init <= 1'b0;
      seen_wake <= 1'b0;
      if (sig_det) begin
        gap_len   <= '0;
        had_burst <= 1'b1;
      end else if (gap_len != LEN_SAT) begin
        gap_len <= gap_len + LEN_W'(1);
      end
      if (rise && had_burst) begin
        if (cls_now == GAP_NONE) begin
          streak_q <= '0;
        end else begin
          cls_q <= cls_now;
          if (streak_n == MATCH_AT) begin
            streak_q  <= '0;
            seen_init <= (cls_now == GAP_INIT);
            seen_wake <= (cls_now == GAP_WAKE);
          end else begin
            streak_q <= streak_n;
          end
        end
      end
    end
  end

endmodule

// File: rtl/oob_signal_unit.sv
module oob_signal_unit #(
  parameter int BURST_CYC     = 16,
  parameter int RESET_GAP_CYC = 48,
  parameter int WAKE_GAP_CYC  = 16,
  parameter int NUM_BURSTS    = 6,
  parameter int INIT_GAP_MIN  = 26,
  parameter int INIT_GAP_MAX  = 79,
  parameter int WAKE_GAP_MIN  = 8,
  parameter int WAKE_GAP_MAX  = 25,
  parameter int MATCH_GAPS    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tx_start,
  input  logic        tx_kind,
  output logic        tx_elec_idle,
  output logic [15:0] tx_data,
  output logic [1:0]  tx_isk,
  output logic        tx_busy,
  output logic        tx_done,
  input  logic        rx_sig_det,
  output logic        rx_cominit,
  output logic        rx_comwake
);

  oob_tx_gen #(
    .BURST_CYC    (BURST_CYC),
    .RESET_GAP_CYC(RESET_GAP_CYC),
    .WAKE_GAP_CYC (WAKE_GAP_CYC),
    .NUM_BURSTS   (NUM_BURSTS)
  ) tx_i (
    .clk      (clk),
    .rst      (rst),
    .start    (tx_start),
    .kind     (tx_kind),
    .elec_idle(tx_elec_idle),
    .data     (tx_data),
    .isk      (tx_isk),
    .busy     (tx_busy),
    .done     (tx_done)
  );

  oob_rx_detect #(
    .INIT_GAP_MIN(INIT_GAP_MIN),
    .INIT_GAP_MAX(INIT_GAP_MAX),
    .WAKE_GAP_MIN(WAKE_GAP_MIN),
    .WAKE_GAP_MAX(WAKE_GAP_MAX),
    .MATCH_GAPS  (MATCH_GAPS)
  ) rx_i (
    .clk      (clk),
    .rst      (rst),
    .sig_det  (rx_sig_det),
    .seen_init(rx_cominit),
    .seen_wake(rx_comwake)
  );

endmodule

// File: rtl/oob_signal_chk.sv
module oob_signal_chk
  import oob_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        tx_elec_idle,
  input logic [15:0] tx_data,
  input logic [1:0]  tx_isk,
  input logic        tx_busy,
  input logic        tx_done,
  input logic        rx_sig_det,
  input logic        rx_cominit,
  input logic        rx_comwake
);

  p_quiet_is_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx_elec_idle);

  p_idle_word_zero_r4: assert property (@(posedge clk) disable iff (rst)
    tx_elec_idle |-> (tx_data == 16'h0000 && tx_isk == 2'b00));

  p_burst_word_align_r4: assert property (@(posedge clk) disable iff (rst)
    !tx_elec_idle |-> ((tx_data == ALIGN_LO && tx_isk == ALIGN_LO_ISK) ||
                       (tx_data == ALIGN_HI && tx_isk == ALIGN_HI_ISK)));

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);

  p_done_after_burst_r5: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (tx_elec_idle && !tx_busy && !$past(tx_elec_idle)));

  p_busy_ends_with_done_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_busy) |-> tx_done);

  p_reports_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(rx_cominit && rx_comwake));

  p_report_at_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_cominit || rx_comwake) |-> ($past(rx_sig_det) && !$past(rx_sig_det, 2)));

endmodule

bind oob_signal_unit oob_signal_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .tx_elec_idle(tx_elec_idle),
  .tx_data     (tx_data),
  .tx_isk      (tx_isk),
  .tx_busy     (tx_busy),
  .tx_done     (tx_done),
  .rx_sig_det  (rx_sig_det),
  .rx_cominit  (rx_cominit),
  .rx_comwake  (rx_comwake)
);

// File: tb/oob_signal_unit_tb_top.sv
module oob_signal_unit_tb_top;

  localparam int B    = 16;
  localparam int RG   = 48;
  localparam int WG   = 16;
  localparam int NB   = 6;
  localparam int IMIN = 26;
  localparam int IMAX = 79;
  localparam int WMIN = 8;
  localparam int WMAX = 25;
  localparam int MG   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_start = 1'b0;
  logic        tx_kind = 1'b0;
  logic        det_drv = 1'b0;
  logic        loop_en = 1'b0;
  logic        tx_elec_idle, tx_busy, tx_done, rx_cominit, rx_comwake;
  logic [15:0] tx_data;
  logic [1:0]  tx_isk;
  logic        rx_sig_det;

  assign rx_sig_det = loop_en ? ~tx_elec_idle : det_drv;

  always #2 clk = ~clk;

  oob_signal_unit #(
    .BURST_CYC(B), .RESET_GAP_CYC(RG), .WAKE_GAP_CYC(WG), .NUM_BURSTS(NB),
    .INIT_GAP_MIN(IMIN), .INIT_GAP_MAX(IMAX), .WAKE_GAP_MIN(WMIN),
    .WAKE_GAP_MAX(WMAX), .MATCH_GAPS(MG)
  ) dut_i (
    .clk(clk), .rst(rst), .tx_start(tx_start), .tx_kind(tx_kind),
    .tx_elec_idle(tx_elec_idle), .tx_data(tx_data), .tx_isk(tx_isk),
    .tx_busy(tx_busy), .tx_done(tx_done), .rx_sig_det(rx_sig_det),
    .rx_cominit(rx_cominit), .rx_comwake(rx_comwake)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  finished = 0;
  int  init_pulses = 0;
  int  wake_pulses = 0;

  always @(negedge clk) begin
    if (!rst) begin
      init_pulses += int'(rx_cominit);
      wake_pulses += int'(rx_comwake);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // receive-side reference model
  int m_streak = 0;
  int m_cls    = 0;
  int m_gap    = 0;
  bit m_had    = 0;
  bit m_lvl    = 0;

  function automatic int classify(input int g);
    if (g >= IMIN && g <= IMAX) return 1;
    if (g >= WMIN && g <= WMAX) return 2;
    return 0;
  endfunction

  task automatic hold(input bit lvl, input int cyc, input string tag);
    int fire;
    int c;
    fire = 0;
    if (lvl && !m_lvl && m_had) begin
      c = classify(m_gap);
      if (c == 0) m_streak = 0;
      else begin
        if (c == m_cls) m_streak++;
        else m_streak = 1;
        m_cls = c;
        if (m_streak == MG) begin
          fire = c;
          m_streak = 0;
        end
      end
    end
    if (lvl) begin
      m_had = 1;
      m_gap = 0;
    end
    m_lvl = lvl;
    det_drv = lvl;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      chk(tag, "rx_cominit", int'(rx_cominit), int'(i == 0 && fire == 1));
      chk(tag, "rx_comwake", int'(rx_comwake), int'(i == 0 && fire == 2));
    end
    if (!lvl) m_gap += cyc;
  endtask

  // one burst followed by gaps, each gap closed by a burst
  task automatic rx_signal(input int g0, input int g1, input int g2,
                           input int g3, input int g4, input string tag);
    int gs[5];
    gs = '{g0, g1, g2, g3, g4};
    hold(0, 100, tag);
    hold(1, 2 + int'($urandom_range(18)), tag);
    for (int j = 0; j < 5; j++) begin
      hold(0, gs[j], tag);
      hold(1, 2 + int'($urandom_range(18)), tag);
    end
  endtask

  task automatic run_tx(input bit kind, input int inject_at, input string tag);
    int gap;
    int total;
    int off;
    bit in_burst;
    gap = kind ? WG : RG;
    total = NB * B + (NB - 1) * gap;
    @(negedge clk);
    tx_start = 1'b1;
    tx_kind = kind;
    @(negedge clk);
    tx_start = 1'b0;
    for (int k = 0; k <= total; k++) begin
      off = k % (B + gap);
      in_burst = (k < total) && (off < B);
      chk(in_burst ? "R2" : "R3", "tx_elec_idle", int'(tx_elec_idle), int'(!in_burst));
      if (inject_at >= 0) chk(tag, "tx_elec_idle", int'(tx_elec_idle), int'(!in_burst));
      if (in_burst)
        chk("R4", "isk_data", int'({tx_isk, tx_data}),
            (off % 2 == 1) ? int'({2'b00, 16'h7B4A}) : int'({2'b01, 16'h4ABC}));
      else
        chk("R4", "isk_data", int'({tx_isk, tx_data}), 0);
      chk("R5", "tx_done", int'(tx_done), int'(k == total));
      chk("R5", "tx_busy", int'(tx_busy), int'(k < total));
      if (k == inject_at) begin
        tx_start = 1'b1;
        tx_kind = ~kind;
      end
      if (k == inject_at + 1) tx_start = 1'b0;
      @(negedge clk);
    end
    tx_start = 1'b0;
  endtask

  function automatic int pick_gap(input int cls);
    int r;
    r = int'($urandom_range(9));
    if (cls == 1) begin
      if (r == 0) return IMIN;
      if (r == 1) return IMAX;
      return IMIN + int'($urandom_range(IMAX - IMIN));
    end
    if (cls == 2) begin
      if (r == 0) return WMIN;
      if (r == 1) return WMAX;
      return WMIN + int'($urandom_range(WMAX - WMIN));
    end
    return 1 + int'($urandom_range(95));
  endfunction

  initial begin
    int ip;
    int wp;
    int c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values while in reset
    chk("R1", "tx_elec_idle", int'(tx_elec_idle), 1);
    chk("R1", "tx_busy", int'(tx_busy), 0);
    chk("R1", "tx_done", int'(tx_done), 0);
    chk("R1", "isk_data", int'({tx_isk, tx_data}), 0);
    chk("R1", "rx_reports", int'({rx_cominit, rx_comwake}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "tx_elec_idle_after", int'(tx_elec_idle), 1);
    chk("R1", "tx_busy_after", int'(tx_busy), 0);

    // R7: gap before any burst does not count (3 more init gaps -> no report)
    hold(0, 48, "R7");
    hold(1, 10, "R7");
    for (int j = 0; j < 3; j++) begin
      hold(0, 48, "R7");
      hold(1, 10, "R7");
    end

    // R8: clean COMINIT and COMWAKE patterns
    rx_signal(RG, RG, RG, RG, RG, "R8");
    rx_signal(WG, WG, WG, WG, WG, "R8");
    // R7 boundaries
    rx_signal(IMIN, IMAX, IMIN, IMAX, IMIN, "R7");
    rx_signal(WMIN, WMAX, WMIN, WMAX, WMIN, "R7");
    rx_signal(IMIN - 1, IMAX + 1, WMIN - 1, IMAX + 1, WMIN - 1, "R7");
    // R9: class change and unclassed gap break the run
    rx_signal(RG, RG, WG, RG, RG, "R9");
    rx_signal(RG, RG, RG, 3, RG, "R9");
    rx_signal(WG, RG, RG, RG, RG, "R9");

    // random receive patterns
    for (int it = 0; it < 40; it++) begin
      c = int'($urandom_range(3));
      if (c == 3)
        rx_signal(pick_gap(0), pick_gap(1), pick_gap(2), pick_gap(0), pick_gap(1), "R9");
      else
        rx_signal(pick_gap(c), pick_gap(c), pick_gap(c), pick_gap(c), pick_gap(c), "R8");
    end
    hold(0, 100, "R8");

    // transmit: both kinds, then ignored start requests
    run_tx(1'b0, -1, "R2");
    run_tx(1'b1, -1, "R3");
    run_tx(1'b0, 5, "R6");
    run_tx(1'b1, 40, "R6");
    run_tx(1'b0, 20 + int'($urandom_range(200)), "R6");

    // R10: loopback from transmit to receive
    loop_en = 1'b1;
    ip = init_pulses;
    wp = wake_pulses;
    run_tx(1'b0, -1, "R10");
    repeat (100) @(negedge clk);
    chk("R10", "cominit_reports", init_pulses - ip, 1);
    chk("R10", "comwake_reports", wake_pulses - wp, 0);
    ip = init_pulses;
    wp = wake_pulses;
    run_tx(1'b1, -1, "R10");
    repeat (100) @(negedge clk);
    chk("R10", "comwake_reports", wake_pulses - wp, 1);
    chk("R10", "cominit_reports", init_pulses - ip, 0);
    loop_en = 1'b0;
    m_had = 1;
    m_lvl = 0;
    m_gap = 1000;
    rx_signal(RG, RG, RG, RG, RG, "R8");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule